// File: doc/BRIEF.md
# Selectable BERT Pattern Generator

This block produces a serial test stream for bit-error-rate measurement, one bit per clock on which the bit-enable strobe is high. A 3-bit select code chooses the stream. The choices are four plain maximal-length pseudorandom sequences, a zero-limited pseudorandom sequence, a repeating user word, a word that alternates with its own complement, and a constant-ones fill.

The select code, the pattern word and the pattern length are taken only on a low-to-high transition of a level load control. The same transition restarts the generator from a known seed. Holding the load control high changes nothing more. An invert enable flips every outgoing bit without disturbing the generator state. The output is combinational from the generator registers and the invert enable. The bit on `tx_bit` is the one being sent now, and a strobed clock edge moves on to the next bit.

Top module: `bert_patgen`

## Requirements
- R1: Select codes 000, 111, 001 and 010 give Fibonacci shift-register sequences with polynomials x^7+x^6+1, x^9+x^5+1, x^11+x^9+1 and x^15+x^14+1. The output is the oldest stage. The new stage is the XOR of the two tap stages. Each sequence repeats every 2^N−1 bits and holds 2^(N−1) ones per period. Its longest run of zeros is N−1.
- R2: Select code 011 uses x^20+x^17+1. The output bit is forced to 1 whenever the 14 bits sent before it were all 0, so no more than 14 zeros in a row ever appear.
- R3: Select code 100 sends pat_word bits L−1 down to 0 and then repeats them, where L = pat_len + 1. pat_len is 5 bits and holds the length minus one, so L runs from 1 to 32.
- R4: Select code 101 sends the same L bits as R3, then those L bits complemented, and then repeats.
- R5: Select code 110 sends constant ones.
- R6: A load happens on a clock edge where load_ctl is 1 and was 0 at the previous edge. On the next cycle the new pattern starts at its first bit. The shift register is seeded with all ones, so the first bit is 1. The word position is at the MSB and the alternating phase is uncomplemented. Changes to pat_sel, pat_word or pat_len at any other time have no effect.
- R7: While load_ctl stays high, no further load takes place. A new load needs load_ctl to go low and then high again.
- R8: The stream advances only on edges where bit_en is 1. Otherwise the current bit holds. A load takes effect whatever the value of bit_en.
- R9: When tx_inv is 1, tx_bit is the complement of the generated bit in the same cycle. When tx_inv is 0, the bit passes unchanged.
- R10: Reset selects code 000 with an all-ones seed and clears the load edge history, so tx_bit is 1 during reset when tx_inv is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Advance strobe, one bit per high cycle |
| pat_sel | input | 3 | Pattern select code |
| load_ctl | input | 1 | Level load control, acts on its rising edge |
| tx_inv | input | 1 | Invert the outgoing stream |
| pat_word | input | 32 | User pattern word |
| pat_len | input | 5 | User pattern length minus one |
| tx_bit | output | 1 | Serial test bit |

## Verification
A wrong tap or a wrong stage width does not show up at once, because every sequence starts with a run of ones after the seed. It shows up as the first differing bit some N bits after a load, and then as a wrong ones count or a wrong period over a full cycle. A lost or extra zero-run forcing in the 20-stage mode shows only when the sequence reaches a long zero run, which can take tens of thousands of bits. For this reason the long runs are compared bit for bit. A fault in the word position or the alternating phase shows within one or two word lengths. A fault in the load edge detection shows on the first cycle after a held or repeated load_ctl.

// File: rtl/bert_pkg.sv
package bert_pkg;

    typedef enum logic [2:0] {
        SEL_P7   = 3'b000,
        SEL_P11  = 3'b001,
        SEL_P15  = 3'b010,
        SEL_QRSS = 3'b011,
        SEL_REP  = 3'b100,
        SEL_ALT  = 3'b101,
        SEL_FILL = 3'b110,
        SEL_P9   = 3'b111
    } bert_sel_e;

    // Index of the oldest stage (the output stage) for each sequence length
    function automatic logic [4:0] prbs_top_idx(input logic [2:0] sel);
        case (sel)
            SEL_P7:   prbs_top_idx = 5'd6;
            SEL_P9:   prbs_top_idx = 5'd8;
            SEL_P11:  prbs_top_idx = 5'd10;
            SEL_P15:  prbs_top_idx = 5'd14;
            SEL_QRSS: prbs_top_idx = 5'd19;
            default:  prbs_top_idx = 5'd6;
        endcase
    endfunction

    // Index of the inner feedback tap stage
    function automatic logic [4:0] prbs_tap_idx(input logic [2:0] sel);
        case (sel)
            SEL_P7:   prbs_tap_idx = 5'd5;
            SEL_P9:   prbs_tap_idx = 5'd4;
            SEL_P11:  prbs_tap_idx = 5'd8;
            SEL_P15:  prbs_tap_idx = 5'd13;
            SEL_QRSS: prbs_tap_idx = 5'd16;
            default:  prbs_tap_idx = 5'd5;
        endcase
    endfunction

endpackage

// File: rtl/bert_load_ctl.sv
module bert_load_ctl
    import bert_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_ctl,
    input  logic [2:0]        pat_sel,
    input  logic [WORD_W-1:0] pat_word,
    input  logic [LEN_W-1:0]  pat_len,
    output logic              load_pulse,
    output logic [2:0]        act_sel,
    output logic [WORD_W-1:0] act_word,
    output logic [LEN_W-1:0]  act_len
);

    typedef struct packed {
        logic              prev;
        logic [2:0]        sel;
        logic [WORD_W-1:0] word;
        logic [LEN_W-1:0]  len;
    } cfg_t;

    cfg_t q, d;

    always_comb begin
        d          = q;
        load_pulse = load_ctl & ~q.prev;
        d.prev     = load_ctl;
        if (load_pulse) begin
            d.sel  = pat_sel;
            d.word = pat_word;
            d.len  = pat_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign act_sel  = q.sel;
    assign act_word = q.word;
    assign act_len  = q.len;

endmodule

// File: rtl/bert_prbs_core.sv
module bert_prbs_core
    import bert_pkg::*;
#(
    parameter int LFSR_W = 20,
    parameter int ZRUN   = 14,
    localparam int ZC_W  = $clog2(ZRUN + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seed,
    input  logic       advance,
    input  logic [2:0] sel,
    output logic       bit_o
);

    typedef struct packed {
        logic [LFSR_W-1:0] sr;
        logic [ZC_W-1:0]   zc;
    } prbs_t;

    prbs_t q, d;

    logic [4:0] top_idx;
    logic [4:0] tap_idx;
    logic       raw_bit;
    logic       force_one;
    logic       fb;
    logic       is_qrss;

    always_comb begin
        top_idx   = prbs_top_idx(sel);
        tap_idx   = prbs_tap_idx(sel);
        is_qrss   = (sel == SEL_QRSS);
        raw_bit   = q.sr[top_idx];
        fb        = q.sr[top_idx] ^ q.sr[tap_idx];
        force_one = is_qrss && (q.zc == ZC_W'(ZRUN));
        bit_o     = raw_bit | force_one;

        d = q;
        if (seed) begin
            d.sr = '1;
            d.zc = '0;
        end else if (advance) begin
            d.sr = {q.sr[LFSR_W-2:0], fb};
            if (is_qrss) begin
                d.zc = bit_o ? '0 : q.zc + 1'b1;
            end else begin
                d.zc = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sr <= '1;
            q.zc <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/bert_word_gen.sv
module bert_word_gen #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed,
    input  logic              advance,
    input  logic              alt_en,
    input  logic [WORD_W-1:0] word,
    input  logic [LEN_W-1:0]  len,
    output logic              bit_o
);

    typedef struct packed {
        logic [LEN_W-1:0] idx;
        logic             ph;
    } wg_t;

    wg_t q, d;

    logic [LEN_W-1:0] pos;

    always_comb begin
        pos   = len - q.idx;
        bit_o = word[pos] ^ (alt_en & q.ph);

        d = q;
        if (seed) begin
            d.idx = '0;
            d.ph  = 1'b0;
        end else if (advance) begin
            if (q.idx == len) begin
                d.idx = '0;
                d.ph  = alt_en ? ~q.ph : 1'b0;
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/bert_patgen.sv
module bert_patgen
    import bert_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LFSR_W = 20,
    parameter int ZRUN   = 14,
    localparam int LEN_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [2:0]        pat_sel,
    input  logic              load_ctl,
    input  logic              tx_inv,
    input  logic [WORD_W-1:0] pat_word,
    input  logic [LEN_W-1:0]  pat_len,
    output logic              tx_bit
);

    logic              load_pulse;
    logic [2:0]        act_sel;
    logic [WORD_W-1:0] act_word;
    logic [LEN_W-1:0]  act_len;
    logic              advance;
    logic              prbs_bit;
    logic              word_bit;
    logic              pat_bit;
    logic              alt_en;

    bert_load_ctl #(
        .WORD_W (WORD_W),
        .LEN_W  (LEN_W)
    ) u_load (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_ctl   (load_ctl),
        .pat_sel    (pat_sel),
        .pat_word   (pat_word),
        .pat_len    (pat_len),
        .load_pulse (load_pulse),
        .act_sel    (act_sel),
        .act_word   (act_word),
        .act_len    (act_len)
    );

    assign advance = bit_en & ~load_pulse;
    assign alt_en  = (act_sel == SEL_ALT);

    bert_prbs_core #(
        .LFSR_W (LFSR_W),
        .ZRUN   (ZRUN)
    ) u_prbs (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed    (load_pulse),
        .advance (advance),
        .sel     (act_sel),
        .bit_o   (prbs_bit)
    );

    bert_word_gen #(
        .WORD_W (WORD_W),
        .LEN_W  (LEN_W)
    ) u_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed    (load_pulse),
        .advance (advance),
        .alt_en  (alt_en),
        .word    (act_word),
        .len     (act_len),
        .bit_o   (word_bit)
    );

    always_comb begin
        case (act_sel)
            SEL_REP, SEL_ALT: pat_bit = word_bit;
            SEL_FILL:         pat_bit = 1'b1;
            default:          pat_bit = prbs_bit;
        endcase
        tx_bit = pat_bit ^ tx_inv;
    end

endmodule

// File: rtl/bert_patgen_chk.sv
module bert_patgen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       load_ctl,
    input logic       tx_inv,
    input logic       tx_bit,
    input logic [2:0] pat_sel,
    input logic [2:0] act_sel
);

    logic       prev_lc_q;
    logic [4:0] run_q;
    logic       sent;
    logic       rise;

    assign sent = tx_bit ^ tx_inv;
    assign rise = load_ctl & ~prev_lc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_lc_q <= 1'b0;
            run_q     <= '0;
        end else begin
            prev_lc_q <= load_ctl;
            if (rise || act_sel != 3'b011) begin
                run_q <= '0;
            end else if (bit_en) begin
                if (sent) begin
                    run_q <= '0;
                end else if (run_q != 5'd31) begin
                    run_q <= run_q + 5'd1;
                end
            end
        end
    end

    assert_zero_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 5'd14);

    assert_fill_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_sel == 3'b110) |-> sent);

    assert_seed_first_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && (pat_sel inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111})) |=> sent);

    assert_held_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ctl && prev_lc_q) |=> $stable(act_sel));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !rise) |=> (sent == $past(sent)));

endmodule

bind bert_patgen bert_patgen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .load_ctl (load_ctl),
    .tx_inv   (tx_inv),
    .tx_bit   (tx_bit),
    .pat_sel  (pat_sel),
    .act_sel  (act_sel)
);

// File: tb/bert_patgen_bench.sv
`timescale 1ns/1ps
module bert_patgen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        load_ctl = 1'b0;
    logic        tx_inv = 1'b0;
    logic [2:0]  pat_sel = 3'b000;
    logic [31:0] pat_word = '0;
    logic [4:0]  pat_len = '0;
    logic        tx_bit;

    always #10 clk = ~clk;

    bert_patgen u_bert_patgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .pat_sel  (pat_sel),
        .load_ctl (load_ctl),
        .tx_inv   (tx_inv),
        .pat_word (pat_word),
        .pat_len  (pat_len),
        .tx_bit   (tx_bit)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    int          m_s, m_zc, m_idx, m_len;
    bit          m_ph;
    logic [2:0]  m_sel;
    logic [31:0] m_w;

    // run statistics
    int st_ones, st_run, st_maxrun;

    function automatic int bn(input logic [2:0] s);
        case (s)
            3'b000: return 7;
            3'b111: return 9;
            3'b001: return 11;
            3'b010: return 15;
            default: return 20;
        endcase
    endfunction

    function automatic int bt(input logic [2:0] s);
        case (s)
            3'b000: return 6;
            3'b111: return 5;
            3'b001: return 9;
            3'b010: return 14;
            default: return 17;
        endcase
    endfunction

    task automatic chk(input logic got, input logic exp, input string req);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic chk_int(input int got, input int exp, input string req);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic m_seed(input logic [2:0] s, input logic [31:0] w, input logic [4:0] l);
        m_sel = s;
        m_w   = w;
        m_len = int'(l) + 1;
        m_s   = (1 << bn(s)) - 1;
        m_zc  = 0;
        m_idx = 0;
        m_ph  = 1'b0;
    endtask

    function automatic bit m_out();
        bit b;
        int n;
        case (m_sel)
            3'b100, 3'b101: b = m_w[m_len - 1 - m_idx] ^ ((m_sel == 3'b101) && m_ph);
            3'b110:         b = 1'b1;
            default: begin
                n = bn(m_sel);
                b = ((m_s >> (n - 1)) & 1) != 0;
                if (m_sel == 3'b011 && m_zc == 14) b = 1'b1;
            end
        endcase
        return b;
    endfunction

    task automatic m_adv();
        bit b;
        int n, t, fb;
        b = m_out();
        case (m_sel)
            3'b100, 3'b101: begin
                m_idx++;
                if (m_idx == m_len) begin
                    m_idx = 0;
                    m_ph  = (m_sel == 3'b101) ? ~m_ph : 1'b0;
                end
            end
            3'b110: ;
            default: begin
                n  = bn(m_sel);
                t  = bt(m_sel);
                fb = ((m_s >> (n - 1)) ^ (m_s >> (t - 1))) & 1;
                if (m_sel == 3'b011) m_zc = b ? 0 : m_zc + 1;
                m_s = ((m_s << 1) | fb) & ((1 << n) - 1);
            end
        endcase
    endtask

    // compare n bits with the model, advancing one bit per cycle
    task automatic run_cmp(input int n, input string req, input int period);
        bit obs;
        st_ones = 0; st_run = 0; st_maxrun = 0;
        for (int i = 0; i < n; i++) begin
            chk(tx_bit, m_out() ^ tx_inv, req);
            obs = tx_bit ^ tx_inv;
            if (i < period && obs) st_ones++;
            if (obs) st_run = 0;
            else begin
                st_run++;
                if (st_run > st_maxrun) st_maxrun = st_run;
            end
            bit_en = 1'b1;
            cyc();
            m_adv();
        end
    endtask

    // rising edge on load_ctl, then low again with the stream held
    task automatic do_load(input logic [2:0] s, input logic [31:0] w, input logic [4:0] l);
        pat_sel  = s;
        pat_word = w;
        pat_len  = l;
        load_ctl = 1'b1;
        cyc();
        m_seed(s, w, l);
        load_ctl = 1'b0;
        bit_en   = 1'b0;
        cyc();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [2:0] psel [4] = '{3'b000, 3'b111, 3'b001, 3'b010};
        logic [4:0] rlen [4] = '{5'd0, 5'd4, 5'd12, 5'd31};
        logic [4:0] alen [3] = '{5'd7, 5'd31, 5'd1};
        int per;
        int n;

        // R10: reset state
        cyc(); cyc();
        chk(tx_bit, 1'b1, "R10 reset output");
        rst_n = 1'b1;
        m_seed(3'b000, '0, '0);
        run_cmp(30, "R10 default sequence", 0);

        // R1 and R6: plain sequences over a full period plus one seed length
        for (int k = 0; k < 4; k++) begin
            n   = bn(psel[k]);
            per = (1 << n) - 1;
            do_load(psel[k], 32'h0, 5'd0);
            chk(tx_bit, 1'b1, "R6 first bit after seed");
            run_cmp(per + n, "R1 sequence", per);
            chk_int(st_ones, 1 << (n - 1), "R1 ones per period");
            chk_int(st_maxrun, n - 1, "R1 longest zero run");
        end

        // R2: zero-limited long sequence
        do_load(3'b011, 32'h0, 5'd0);
        run_cmp(60000, "R2 sequence", 0);
        chk(st_maxrun <= 14, 1'b1, "R2 zero run limit");

        // R3: repeating word at several lengths
        for (int k = 0; k < 4; k++) begin
            do_load(3'b100, 32'hB4E1_96C3 ^ (32'h1111_0001 * k), rlen[k]);
            run_cmp(3 * (int'(rlen[k]) + 1) + 2, "R3 repeat word", 0);
        end

        // R4: alternating word
        for (int k = 0; k < 3; k++) begin
            do_load(3'b101, 32'h6D2B_F018 + k, alen[k]);
            run_cmp(4 * (int'(alen[k]) + 1) + 1, "R4 alternating word", 0);
        end

        // R5: fill code
        do_load(3'b110, 32'h0, 5'd9);
        run_cmp(64, "R5 constant ones", 0);
        chk_int(st_maxrun, 0, "R5 no zeros");

        // R9: inversion
        do_load(3'b000, 32'h0, 5'd0);
        run_cmp(10, "R9 before invert", 0);
        tx_inv = 1'b1;
        #1;
        chk(tx_bit, ~m_out(), "R9 same-cycle invert");
        run_cmp(40, "R9 inverted stream", 0);
        tx_inv = 1'b0;

        // R8 hold and R6 ignored inputs without a load edge
        do_load(3'b001, 32'h0, 5'd0);
        run_cmp(25, "R8 before hold", 0);
        for (int i = 0; i < 6; i++) begin
            bit_en   = 1'b0;
            pat_sel  = 3'b110;
            pat_word = 32'hFFFF_0000 >> i;
            pat_len  = 5'(i);
            #1;
            chk(tx_bit, m_out(), "R8 hold with bit_en low");
            cyc();
        end
        run_cmp(30, "R6 select change without load ignored", 0);

        // R8: load takes effect with bit_en low
        bit_en   = 1'b0;
        pat_sel  = 3'b100;
        pat_word = 32'h0000_0029;
        pat_len  = 5'd5;
        load_ctl = 1'b1;
        cyc();
        m_seed(3'b100, 32'h0000_0029, 5'd5);
        chk(tx_bit, m_out(), "R8 load with bit_en low");

        // R7: held load does nothing more
        pat_sel  = 3'b110;
        pat_word = 32'h0;
        pat_len  = 5'd2;
        run_cmp(14, "R7 held load ignored", 0);
        load_ctl = 1'b0;
        run_cmp(3, "R7 after release", 0);
        load_ctl = 1'b1;
        cyc();
        m_seed(3'b110, 32'h0, 5'd2);
        load_ctl = 1'b0;
        run_cmp(10, "R7 reload after low", 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule